// File: doc/BRIEF.md
# Framed 24-bit serial write receiver

This block receives command words for a multi-channel converter control port over a serial link that has three wires: an active-low frame select, a serial clock and a serial data line. It runs on a fast system clock. It passes all three wires through synchronizers and finds the edges of the serial clock and of the frame select from successive samples, so the system clock must run at least four times faster than the serial clock. Inside a frame, each falling edge of the serial clock shifts in one data bit, most significant bit first. When the frame ends, the word splits into a 2-bit mode, a 6-bit register address and a data field.

A register write is issued only when the frame select rises after exactly 24 falling serial-clock edges. A frame that closes early gives a one-cycle abort pulse. A frame that received too many clock edges gives a one-cycle overrun pulse. Neither kind of bad frame touches the output fields. A parameter selects a narrow variant that has 14 data bits, with the two lowest data bits reserved as zero. The serial clock may run freely or arrive as a gated burst of exactly 24 pulses.

Top module: `spiw_rx`

## Requirements
- R1: After synchronous reset, wr_strobe, abort_pulse and overrun_pulse are low, and mode, addr and data are all zero.
- R2: The word is received most significant bit first. On a write, mode takes word bits 23:22, addr takes bits 21:16 and data takes bits 15:0. These fields keep their values until the next write.
- R3: A data bit is taken only at a falling edge of the serial clock while the frame select is low. The data value present at a rising edge has no effect.
- R4: If the frame select rises after 1 to 23 falling clock edges, abort_pulse is high for one cycle, no write occurs and the fields stay unchanged.
- R5: If the frame select rises after exactly 24 falling edges, wr_strobe is high for exactly one cycle. It rises at the second system-clock edge after the edge that first samples the frame-select rise.
- R6: If the frame select rises after 25 or more falling edges, overrun_pulse is high for one cycle, no write occurs and the fields stay unchanged.
- R7: A frame with no clock edges gives no pulse. Serial-clock edges while the frame select is high give no pulse and are not counted toward the next frame.
- R8: Each frame that saw at least one falling clock edge gives exactly one of the three pulses. No two of the pulses are ever high together.
- R9: With NARROW=1, data[1:0] always reads zero and data[15:2] takes word bits 15:2.
- R10: A free-running clock whose 25th falling edge arrives after the frame select has risen commits the same way as a gated burst of exactly 24 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data, taken at falling sclk edges |
| wr_strobe | output | 1 | One-cycle pulse when a complete word is committed |
| mode | output | 2 | Mode field of the last committed word |
| addr | output | 6 | Register address of the last committed word |
| data | output | 16 | Data field of the last committed word |
| abort_pulse | output | 1 | One-cycle pulse for a frame that closed early |
| overrun_pulse | output | 1 | One-cycle pulse for a frame with too many clock edges |

## Verification
Several frame lengths are applied: 1, 23, 24, 25 and 30 falling edges. This shows whether the counter separates the commit boundary from the abort case and the overrun case on both sides. Gated and free-running clocks are both used, which shows whether an edge arriving after the frame select has risen leaks into the count. In one pattern the data line carries the wrong value at each rising edge and only settles before the falling edge, which separates falling-edge sampling from rising-edge sampling. Clock toggles while the frame is idle, and a frame with no clock at all, check that idle activity stays silent. A second instance built in the narrow variant receives a word whose reserved bits are set.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
    localparam int unsigned DEF_WORD_W = 24;
    localparam int unsigned DEF_MODE_W = 2;
    localparam int unsigned DEF_ADDR_W = 6;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_RSV_W  = 2;

    typedef enum logic [1:0] {
        FE_NONE,
        FE_WRITE,
        FE_ABORT,
        FE_OVERRUN
    } frame_end_e;
endpackage

// File: rtl/spiw_sync.sv
module spiw_sync #(
    parameter int unsigned     N      = 3,
    parameter int unsigned     N_EDGE = 2,
    parameter logic [N-1:0]    RST    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      raw,
    output logic [N-1:0]      cur,
    output logic [N_EDGE-1:0] prev
);
    localparam int unsigned LO = N - N_EDGE;

    logic [N-1:0] meta_q;
    logic [N-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST;
            cur_q  <= RST;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
        end
    end

    assign cur = cur_q;

    // history stage only on the bits whose edges are needed
    for (genvar i = 0; i < N_EDGE; i++) begin : g_hist
        logic hist_q;
        always_ff @(posedge clk) begin
            if (rst) hist_q <= RST[LO + i];
            else     hist_q <= cur_q[LO + i];
        end
        assign prev[i] = hist_q;
    end
endmodule

// File: rtl/spiw_decode.sv
module spiw_decode #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned MODE_W = 2,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned RSV_W  = 2,
    parameter bit          NARROW = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    output logic [MODE_W-1:0] mode,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    assign mode = word[WORD_W-1 -: MODE_W];
    assign addr = word[DATA_W +: ADDR_W];

    if (NARROW) begin : g_narrow
        assign data = {word[DATA_W-1:RSV_W], {RSV_W{1'b0}}};
    end else begin : g_wide
        assign data = word[DATA_W-1:0];
    end
endmodule

// File: rtl/spiw_framer.sv
module spiw_framer
    import spiw_pkg::*;
#(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned MODE_W = 2,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_cur,
    input  logic              cs_prev,
    input  logic              sclk_cur,
    input  logic              sclk_prev,
    input  logic              sdi_cur,
    input  logic [MODE_W-1:0] dec_mode,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [DATA_W-1:0] dec_data,
    output logic [WORD_W-1:0] word,
    output logic              wr_strobe,
    output logic              abort_pulse,
    output logic              overrun_pulse,
    output logic [MODE_W-1:0] mode,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned        CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0]   FULL  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0]   OVER  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              wr;
        logic              ab;
        logic              ov;
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t        st_d, st_q;
    frame_end_e outcome;
    logic       cs_fall, cs_rise, sclk_fall;

    assign cs_fall   =  cs_prev   & ~cs_cur;
    assign cs_rise   = ~cs_prev   &  cs_cur;
    assign sclk_fall =  sclk_prev & ~sclk_cur;

    always_comb begin
        if (st_q.cnt == FULL)         outcome = FE_WRITE;
        else if (st_q.cnt > FULL)     outcome = FE_OVERRUN;
        else if (st_q.cnt != '0)      outcome = FE_ABORT;
        else                          outcome = FE_NONE;
    end

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        st_d.ab = 1'b0;
        st_d.ov = 1'b0;
        if (cs_cur && !cs_rise) begin
            // idle: counter and shifter held cleared
            st_d.cnt   = '0;
            st_d.shreg = '0;
        end
        if (cs_rise) begin
            st_d.active = 1'b0;
            if (st_q.active) begin
                unique case (outcome)
                    FE_WRITE: begin
                        st_d.wr   = 1'b1;
                        st_d.mode = dec_mode;
                        st_d.addr = dec_addr;
                        st_d.data = dec_data;
                    end
                    FE_ABORT:   st_d.ab = 1'b1;
                    FE_OVERRUN: st_d.ov = 1'b1;
                    default: ;
                endcase
            end
        end else if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.shreg  = '0;
        end else if (st_q.active && !cs_cur && sclk_fall) begin
            if (st_q.cnt < FULL) st_d.shreg = {st_q.shreg[WORD_W-2:0], sdi_cur};
            if (st_q.cnt < OVER) st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word          = st_q.shreg;
    assign wr_strobe     = st_q.wr;
    assign abort_pulse   = st_q.ab;
    assign overrun_pulse = st_q.ov;
    assign mode          = st_q.mode;
    assign addr          = st_q.addr;
    assign data          = st_q.data;
endmodule

// File: rtl/spiw_rx.sv
module spiw_rx
    import spiw_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned MODE_W = DEF_MODE_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned RSV_W  = DEF_RSV_W,
    parameter bit          NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              wr_strobe,
    output logic [MODE_W-1:0] mode,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              abort_pulse,
    output logic              overrun_pulse
);
    localparam int unsigned N_IN   = 3;
    localparam int unsigned N_EDGE = 2;

    logic [N_IN-1:0]   s_cur;
    logic [N_EDGE-1:0] s_prev;
    logic [WORD_W-1:0] word;
    logic [MODE_W-1:0] dec_mode;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_data;

    // bit 2: frame select (idle high), bit 1: serial clock, bit 0: data
    spiw_sync #(.N(N_IN), .N_EDGE(N_EDGE), .RST(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({cs_n, sclk, sdi}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    spiw_decode #(
        .WORD_W(WORD_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .RSV_W(RSV_W), .NARROW(NARROW)
    ) u_dec (
        .word (word),
        .mode (dec_mode),
        .addr (dec_addr),
        .data (dec_data)
    );

    spiw_framer #(
        .WORD_W(WORD_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_frm (
        .clk           (clk),
        .rst           (rst),
        .cs_cur        (s_cur[2]),
        .cs_prev       (s_prev[1]),
        .sclk_cur      (s_cur[1]),
        .sclk_prev     (s_prev[0]),
        .sdi_cur       (s_cur[0]),
        .dec_mode      (dec_mode),
        .dec_addr      (dec_addr),
        .dec_data      (dec_data),
        .word          (word),
        .wr_strobe     (wr_strobe),
        .abort_pulse   (abort_pulse),
        .overrun_pulse (overrun_pulse),
        .mode          (mode),
        .addr          (addr),
        .data          (data)
    );
endmodule

// File: rtl/spiw_rx_chk.sv
module spiw_rx_chk #(
    parameter int unsigned MODE_W = 2,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned RSV_W  = 2,
    parameter bit          NARROW = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_strobe,
    input logic              abort_pulse,
    input logic              overrun_pulse,
    input logic [MODE_W-1:0] mode,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
);
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_strobe, abort_pulse, overrun_pulse}));

    assert_write_single_R5: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    assert_abort_single_R4: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    assert_overrun_single_R6: assert property (@(posedge clk) disable iff (rst)
        overrun_pulse |=> !overrun_pulse);

    assert_fields_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |-> $stable({mode, addr, data}));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        NARROW |-> (data[RSV_W-1:0] == '0));
endmodule

bind spiw_rx spiw_rx_chk #(
    .MODE_W(MODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RSV_W(RSV_W), .NARROW(NARROW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_strobe     (wr_strobe),
    .abort_pulse   (abort_pulse),
    .overrun_pulse (overrun_pulse),
    .mode          (mode),
    .addr          (addr),
    .data          (data)
);

// File: tb/spiw_rx_tb.sv
module spiw_rx_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;

    logic        wr, ab, ov, wr_n, ab_n, ov_n;
    logic [1:0]  mode, mode_n;
    logic [5:0]  addr, addr_n;
    logic [15:0] data, data_n;

    int checks = 0, failures = 0;
    int cnt_wr = 0, cnt_ab = 0, cnt_ov = 0;

    always #4 clk = ~clk;

    spiw_rx u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .wr_strobe(wr), .mode(mode), .addr(addr), .data(data),
        .abort_pulse(ab), .overrun_pulse(ov)
    );

    spiw_rx #(.NARROW(1'b1)) u_dut_n (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .wr_strobe(wr_n), .mode(mode_n), .addr(addr_n), .data(data_n),
        .abort_pulse(ab_n), .overrun_pulse(ov_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]  h0 = 3'b100, h1 = 3'b100, h2 = 3'b100, h3 = 3'b100;
    bit          m_active = 0;
    int          m_edges  = 0;
    bit          m_bits[$];
    logic        e_wr = 0, e_ab = 0, e_ov = 0;
    logic [23:0] e_word = '0;

    always @(posedge clk) begin
        if (rst) begin
            h0 = 3'b100; h1 = 3'b100; h2 = 3'b100; h3 = 3'b100;
            m_active = 0; m_edges = 0; m_bits.delete();
            e_wr = 0; e_ab = 0; e_ov = 0; e_word = '0;
        end else begin
            h3 = h2; h2 = h1; h1 = h0; h0 = {cs_n, sclk, sdi};
            e_wr = 0; e_ab = 0; e_ov = 0;
            if (h3[2] == 1'b0 && h2[2] == 1'b1) begin
                if (m_active) begin
                    if (m_edges == 24) begin
                        e_wr = 1;
                        for (int i = 0; i < 24; i++) e_word[23-i] = m_bits[i];
                    end else if (m_edges > 24) e_ov = 1;
                    else if (m_edges > 0) e_ab = 1;
                end
                m_active = 0;
            end else if (h3[2] == 1'b1 && h2[2] == 1'b0) begin
                m_active = 1; m_edges = 0; m_bits.delete();
            end else if (m_active && h2[2] == 1'b0 && h3[1] && !h2[1]) begin
                m_edges++;
                if (m_edges <= 24) m_bits.push_back(h2[0]);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            cnt_wr += int'(wr); cnt_ab += int'(ab); cnt_ov += int'(ov);
            chk(wr == e_wr, "R5 wr_strobe vs model", wr, e_wr);
            chk(ab == e_ab, "R4 abort_pulse vs model", ab, e_ab);
            chk(ov == e_ov, "R6 overrun_pulse vs model", ov, e_ov);
            chk({mode, addr, data} == e_word, "R2 fields vs model", {mode, addr, data}, e_word);
            chk(data_n == {e_word[15:2], 2'b00}, "R9 narrow data vs model", data_n, {e_word[15:2], 2'b00});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [23:0] w, input int nf, input bit freerun, input bit skew);
        cs_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < nf; i++) begin
            logic b;
            b = (i < 24) ? w[23-i] : 1'b1;
            sclk = 1'b1;
            if (skew) begin
                sdi = ~b; wait_n(2); sdi = b; wait_n(2);
            end else begin
                sdi = b; wait_n(4);
            end
            sclk = 1'b0;
            wait_n(4);
            if (skew) sdi = ~b;
        end
        if (freerun) begin
            sclk = 1'b1; wait_n(2);
            cs_n = 1'b1; wait_n(2);
            sclk = 1'b0; wait_n(4);
        end else begin
            cs_n = 1'b1;
        end
        wait_n(10);
        #1;
    endtask

    task automatic run(input logic [23:0] w, input int nf, input bit freerun, input bit skew,
                       input int xw, input int xa, input int xo, input logic [23:0] xfields,
                       input string tag);
        int w0, a0, o0;
        w0 = cnt_wr; a0 = cnt_ab; o0 = cnt_ov;
        frame(w, nf, freerun, skew);
        chk(cnt_wr - w0 == xw, {tag, " write count"}, cnt_wr - w0, xw);
        chk(cnt_ab - a0 == xa, {tag, " abort count"}, cnt_ab - a0, xa);
        chk(cnt_ov - o0 == xo, {tag, " overrun count"}, cnt_ov - o0, xo);
        if (nf > 0)
            chk((cnt_wr - w0) + (cnt_ab - a0) + (cnt_ov - o0) == 1, "R8 one outcome per frame",
                (cnt_wr - w0) + (cnt_ab - a0) + (cnt_ov - o0), 1);
        chk({mode, addr, data} == xfields, {tag, " fields"}, {mode, addr, data}, xfields);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        wait_n(5);
        #1;
        chk({wr, ab, ov} == 3'b000, "R1 pulses after reset", {wr, ab, ov}, 0);
        chk({mode, addr, data} == 24'h0, "R1 fields after reset", {mode, addr, data}, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_n(5);

        // R5 / R2: gated burst of 24
        run(24'hA5_1234, 24, 0, 0, 1, 0, 0, 24'hA5_1234, "R5 gated commit");
        chk(mode == 2'b10 && addr == 6'h25, "R2 mode/addr split", {mode, addr}, {2'b10, 6'h25});
        chk(data_n == 16'h1234, "R9 narrow data", data_n, 16'h1234);
        // R10: free-running clock
        run(24'h5A_C3E1, 24, 1, 0, 1, 0, 0, 24'h5A_C3E1, "R10 free-running commit");
        // R4: short frames
        run(24'hFF_FFFF, 23, 0, 0, 0, 1, 0, 24'h5A_C3E1, "R4 abort at 23");
        run(24'h00_0000, 1, 1, 0, 0, 1, 0, 24'h5A_C3E1, "R4 abort at 1");
        // R6: overclocked frames
        run(24'h12_3456, 25, 0, 0, 0, 0, 1, 24'h5A_C3E1, "R6 overrun at 25");
        run(24'h65_4321, 30, 0, 0, 0, 0, 1, 24'h5A_C3E1, "R6 overrun at 30");
        // R7: frame with no clock edges
        run(24'h0, 0, 0, 0, 0, 0, 0, 24'h5A_C3E1, "R7 empty frame");
        // R7: sclk toggles while idle, then a proper frame must still count from zero
        for (int i = 0; i < 6; i++) begin
            sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
        end
        #1;
        chk({wr, ab, ov} == 3'b000, "R7 idle clocks silent", {wr, ab, ov}, 0);
        run(24'h3C_0FF0, 24, 0, 0, 1, 0, 0, 24'h3C_0FF0, "R7 count restarts");
        // R3: wrong value present at rising edges
        run(24'h96_A55B, 24, 0, 1, 1, 0, 0, 24'h96_A55B, "R3 falling-edge sampling");
        chk(data_n == 16'hA558, "R9 reserved bits cleared", data_n, 16'hA558);
        run(24'hFF_FFFF, 24, 1, 1, 1, 0, 0, 24'hFF_FFFF, "R10 free-running all ones");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule